// File: doc/BRIEF.md
# Accumulator register-operation unit

This unit carries out the accumulator and extension-flag operations of a small 16-bit processor's register-operation instruction group. The decoder raises `en` in the execute step of an instruction whose opcode field is all ones and whose indirect bit is clear. The unit receives the low twelve bits of the instruction, the present accumulator value and the extension flag. It returns the values that the accumulator and the flag are to load, a request to advance the program counter by one, a request to stop the machine, and a request to restart the step counter.

The unit is purely combinational, so its results are ready in the same cycle as `en`. Each of the twelve instruction bits selects one operation. Programs normally set a single bit. When more than one bit is set, the accumulator and flag operations are applied as a chain, working from bit 11 down to bit 5, and each step uses the result of the step before it. The skip tests always look at the values that were presented at the input, and their results are ORed together.

Top module: `regref_unit`

## Requirements
- R1: While `en` is low, `ac_nxt` equals `ac_in`, `e_nxt` equals `e_in`, and `skip_req`, `halt_req` and `sc_clr` are all low, whatever the value of `ir_lo`.
- R2: While `en` is high, `sc_clr` is high for every value of `ir_lo`.
- R3: Bit 11 (code 7800 hex) sets the accumulator to zero. Bit 10 (code 7400 hex) sets the flag to zero. Each leaves the other register unchanged.
- R4: Bit 9 (code 7200 hex) inverts every accumulator bit. Bit 8 (code 7100 hex) inverts the flag. Each leaves the other register unchanged.
- R5: Bit 7 (code 7080 hex) rotates the 17-bit value {flag, accumulator} right. The accumulator's bit 15 takes the old flag, and the flag takes the old accumulator bit 0.
- R6: Bit 6 (code 7040 hex) rotates left. The accumulator's bit 0 takes the old flag, and the flag takes the old accumulator bit 15.
- R7: Bit 5 (code 7020 hex) adds one to the accumulator. FFFF becomes 0000, and the flag is unchanged.
- R8: Bit 4 (7010 hex) requests a skip when accumulator bit 15 is 0. Bit 3 (7008 hex) requests a skip when that bit is 1.
- R9: Bit 2 (7004 hex) requests a skip when the accumulator is zero. Bit 1 (7002 hex) requests a skip when the flag is zero.
- R10: Bit 0 (7001 hex) raises `halt_req`. The accumulator and the flag are unchanged, and no skip is requested.
- R11: When several bits are set, bits 11 down to 5 are applied in that order, each to the result of the one before. Skip requests are the OR of the individual tests, all evaluated on `ac_in` and `e_in`.
- R12: With `en` high and no bit set, the accumulator and the flag pass through unchanged, and only `sc_clr` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Execute strobe for a register-operation instruction |
| ir_lo | input | 12 | Low instruction bits; each bit selects one operation |
| ac_in | input | 16 | Current accumulator |
| e_in | input | 1 | Current extension flag |
| ac_nxt | output | 16 | Value for the accumulator to load |
| e_nxt | output | 1 | Value for the extension flag to load |
| skip_req | output | 1 | Request to advance the program counter by one |
| halt_req | output | 1 | Request to clear the run flip-flop |
| sc_clr | output | 1 | Request to clear the step counter |

## Verification
Each single-bit code is applied to accumulator values chosen so that a wrong operation shows up. The values 8001 and 0001 separate a rotate that goes through the flag from a plain shift, and from a rotate in the wrong direction. FFFF with the flag set shows whether increment wraps and whether it leaves the flag alone. Each skip code is tried with its condition both true and false, to separate sign tests from zero tests. Mixed codes such as clear-then-increment, and clear combined with the zero test, show whether the chain order is right and whether the skips read the input values rather than the results.

// File: rtl/rru_pkg.sv
package rru_pkg;
  // Chained accumulator/flag operations, in order of application.
  typedef enum logic [2:0] {
    OP_CLA = 3'd0,
    OP_CLE = 3'd1,
    OP_CMA = 3'd2,
    OP_CME = 3'd3,
    OP_CIR = 3'd4,
    OP_CIL = 3'd5,
    OP_INC = 3'd6
  } alu_op_e;

  localparam int unsigned NUM_ALU_OPS = 7;
  localparam int unsigned SKIP_LSB    = 1;
  localparam int unsigned SKIP_N      = 4;
  localparam int unsigned HALT_BIT    = 0;

  // Instruction bit that selects chain stage k.
  function automatic int unsigned stage_bit(int unsigned ctrl_w, int unsigned k);
    return ctrl_w - 1 - k;
  endfunction
endpackage

// File: rtl/rru_stage.sv
module rru_stage #(
  parameter int unsigned      DATA_W = 16,
  parameter rru_pkg::alu_op_e OP     = rru_pkg::OP_CLA
) (
  input  logic              sel,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              e_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              e_o
);
  // Returns {flag, accumulator}.
  function automatic logic [DATA_W:0] rot_right(logic [DATA_W-1:0] a, logic f);
    return {a[0], f, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W:0] rot_left(logic [DATA_W-1:0] a, logic f);
    return {a[DATA_W-1], a[DATA_W-2:0], f};
  endfunction

  function automatic logic [DATA_W-1:0] incr(logic [DATA_W-1:0] a);
    return a + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  logic [DATA_W-1:0] ac_op;
  logic              e_op;

  generate
    if (OP == rru_pkg::OP_CLA) begin : g_cla
      assign ac_op = '0;
      assign e_op  = e_i;
    end else if (OP == rru_pkg::OP_CLE) begin : g_cle
      assign ac_op = ac_i;
      assign e_op  = 1'b0;
    end else if (OP == rru_pkg::OP_CMA) begin : g_cma
      assign ac_op = ~ac_i;
      assign e_op  = e_i;
      always_comb begin
        if (sel)
          a_r4_cma_disjoint: assert (((ac_o & ac_i) == '0) && ((ac_o | ac_i) == '1) && (e_o == e_i));
      end
    end else if (OP == rru_pkg::OP_CME) begin : g_cme
      assign ac_op = ac_i;
      assign e_op  = ~e_i;
    end else if (OP == rru_pkg::OP_CIR) begin : g_cir
      assign {e_op, ac_op} = rot_right(ac_i, e_i);
      always_comb begin
        if (sel)
          a_r5_rotr_popcount: assert ($countones({e_o, ac_o}) == $countones({e_i, ac_i}));
      end
    end else if (OP == rru_pkg::OP_CIL) begin : g_cil
      assign {e_op, ac_op} = rot_left(ac_i, e_i);
      always_comb begin
        if (sel)
          a_r6_rotl_popcount: assert ($countones({e_o, ac_o}) == $countones({e_i, ac_i}));
      end
    end else begin : g_inc
      assign ac_op = incr(ac_i);
      assign e_op  = e_i;
      always_comb begin
        if (sel)
          a_r7_inc_step: assert ((ac_o - ac_i == {{(DATA_W-1){1'b0}}, 1'b1}) && (e_o == e_i));
      end
    end
  endgenerate

  assign ac_o = sel ? ac_op : ac_i;
  assign e_o  = sel ? e_op  : e_i;
endmodule

// File: rtl/rru_cond.sv
module rru_cond #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              en,
  input  logic [3:0]        tst,   // [3]=sign clear, [2]=sign set, [1]=acc zero, [0]=flag zero
  input  logic [DATA_W-1:0] ac,
  input  logic              e,
  output logic              skip
);
  function automatic logic [3:0] cond_hits(logic [DATA_W-1:0] a, logic f);
    return {~a[DATA_W-1], a[DATA_W-1], (a == '0), ~f};
  endfunction

  logic [3:0] hits;
  assign hits = cond_hits(ac, e) & tst;
  assign skip = en & (|hits);

  always_comb begin
    if (en && tst == 4'b1100)
      a_r8_sign_pair_skips: assert (skip);
  end
endmodule

// File: rtl/regref_unit.sv
module regref_unit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 12
) (
  input  logic              en,
  input  logic [CTRL_W-1:0] ir_lo,
  input  logic [DATA_W-1:0] ac_in,
  input  logic              e_in,
  output logic [DATA_W-1:0] ac_nxt,
  output logic              e_nxt,
  output logic              skip_req,
  output logic              halt_req,
  output logic              sc_clr
);
  localparam int unsigned NOPS = rru_pkg::NUM_ALU_OPS;

  logic [DATA_W-1:0] ac_ch [0:NOPS];
  logic              e_ch  [0:NOPS];

  assign ac_ch[0] = ac_in;
  assign e_ch[0]  = e_in;

  generate
    for (genvar k = 0; k < NOPS; k++) begin : g_chain
      logic stage_sel;
      assign stage_sel = en & ir_lo[rru_pkg::stage_bit(CTRL_W, k)];
      rru_stage #(
        .DATA_W (DATA_W),
        .OP     (rru_pkg::alu_op_e'(k))
      ) u_stage (
        .sel  (stage_sel),
        .ac_i (ac_ch[k]),
        .e_i  (e_ch[k]),
        .ac_o (ac_ch[k+1]),
        .e_o  (e_ch[k+1])
      );
    end
  endgenerate

  rru_cond #(.DATA_W(DATA_W)) u_cond (
    .en   (en),
    .tst  (ir_lo[rru_pkg::SKIP_LSB +: rru_pkg::SKIP_N]),
    .ac   (ac_in),
    .e    (e_in),
    .skip (skip_req)
  );

  assign ac_nxt   = ac_ch[NOPS];
  assign e_nxt    = e_ch[NOPS];
  assign halt_req = en & ir_lo[rru_pkg::HALT_BIT];
  assign sc_clr   = en;

  always_comb begin
    if (!en)
      a_r1_idle_pass: assert (ac_nxt == ac_in && e_nxt == e_in && !skip_req && !halt_req && !sc_clr);
    if (en)
      a_r2_sc_clear: assert (sc_clr);
    if (en && ir_lo == {1'b1, {(CTRL_W-1){1'b0}}})
      a_r3_cla_zero: assert (ac_nxt == '0 && e_nxt == e_in);
    if (en && ir_lo == {{(CTRL_W-1){1'b0}}, 1'b1})
      a_r10_halt_keeps: assert (halt_req && ac_nxt == ac_in && e_nxt == e_in && !skip_req);
    if (en && ir_lo == '0)
      a_r12_nop_pass: assert (ac_nxt == ac_in && e_nxt == e_in && !skip_req && !halt_req);
  end
endmodule

// File: tb/test_regref_unit.sv
module test_regref_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [11:0] ir_lo = '0;
  logic [15:0] ac_in = '0;
  logic        e_in = 1'b0;
  logic [15:0] ac_nxt;
  logic        e_nxt, skip_req, halt_req, sc_clr;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  regref_unit i_regref_unit (
    .en(en), .ir_lo(ir_lo), .ac_in(ac_in), .e_in(e_in),
    .ac_nxt(ac_nxt), .e_nxt(e_nxt), .skip_req(skip_req),
    .halt_req(halt_req), .sc_clr(sc_clr)
  );

  // Reference: {sc, halt, skip, e, ac}
  function automatic logic [19:0] expect_of(logic g, logic [11:0] ir, logic [15:0] ac, logic e);
    logic [15:0] a;
    logic f, s;
    a = ac; f = e;
    if (!g) return {3'b000, e, ac};
    if (ir[11]) a = 16'h0000;
    if (ir[10]) f = 1'b0;
    if (ir[9])  a = a ^ 16'hFFFF;
    if (ir[8])  f = !f;
    if (ir[7])  {a, f} = {f, a};
    if (ir[6])  {f, a} = {a, f};
    if (ir[5])  a = a + 16'd1;
    s = (ir[4] && ac[15] == 1'b0) || (ir[3] && ac[15] == 1'b1) ||
        (ir[2] && ac == 16'd0) || (ir[1] && e == 1'b0);
    return {1'b1, ir[0], s, f, a};
  endfunction

  task automatic apply(input string req, input logic g, input logic [11:0] ir,
                       input logic [15:0] ac, input logic e);
    logic [19:0] exp_v, act_v;
    @(posedge clk);
    en = g; ir_lo = ir; ac_in = ac; e_in = e;
    @(negedge clk);
    exp_v = expect_of(g, ir, ac, e);
    act_v = {sc_clr, halt_req, skip_req, e_nxt, ac_nxt};
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: en=%0b ir=%03h ac=%04h e=%0b actual=%05h expected=%05h",
               req, g, ir, ac, e, act_v, exp_v);
    end
  endtask

  task automatic t_reset_idle;  // R1 after reset and with bits set
    apply("R1", 1'b0, 12'h000, 16'h0000, 1'b0);
    apply("R1", 1'b0, 12'hFFF, 16'h1234, 1'b1);
    apply("R1", 1'b0, 12'h801, 16'h0000, 1'b0);
  endtask

  task automatic t_clear;  // R2 R3
    apply("R3", 1'b1, 12'h800, 16'hBEEF, 1'b1);
    apply("R3", 1'b1, 12'h400, 16'hBEEF, 1'b1);
    apply("R2", 1'b1, 12'h400, 16'h0000, 1'b0);
  endtask

  task automatic t_complement;  // R4
    apply("R4", 1'b1, 12'h200, 16'h5A0F, 1'b0);
    apply("R4", 1'b1, 12'h100, 16'h5A0F, 1'b0);
    apply("R4", 1'b1, 12'h100, 16'h5A0F, 1'b1);
  endtask

  task automatic t_rotate;  // R5 R6
    apply("R5", 1'b1, 12'h080, 16'h8001, 1'b0);
    apply("R5", 1'b1, 12'h080, 16'h0002, 1'b1);
    apply("R6", 1'b1, 12'h040, 16'h8001, 1'b0);
    apply("R6", 1'b1, 12'h040, 16'h4000, 1'b1);
  endtask

  task automatic t_increment;  // R7
    apply("R7", 1'b1, 12'h020, 16'hFFFF, 1'b1);
    apply("R7", 1'b1, 12'h020, 16'h00FF, 1'b0);
  endtask

  task automatic t_sign_skip;  // R8
    apply("R8", 1'b1, 12'h010, 16'h7FFF, 1'b1);
    apply("R8", 1'b1, 12'h010, 16'h8000, 1'b1);
    apply("R8", 1'b1, 12'h008, 16'h8000, 1'b1);
    apply("R8", 1'b1, 12'h008, 16'h0001, 1'b1);
  endtask

  task automatic t_zero_skip;  // R9
    apply("R9", 1'b1, 12'h004, 16'h0000, 1'b1);
    apply("R9", 1'b1, 12'h004, 16'h0100, 1'b0);
    apply("R9", 1'b1, 12'h002, 16'h0100, 1'b0);
    apply("R9", 1'b1, 12'h002, 16'h0000, 1'b1);
  endtask

  task automatic t_halt;  // R10
    apply("R10", 1'b1, 12'h001, 16'hCAFE, 1'b1);
  endtask

  task automatic t_multi;  // R11
    apply("R11", 1'b1, 12'h820, 16'h1234, 1'b0);  // clear then increment
    apply("R11", 1'b1, 12'h280, 16'h0001, 1'b1);  // invert then rotate right
    apply("R11", 1'b1, 12'h804, 16'h0005, 1'b0);  // zero test reads input
    apply("R11", 1'b1, 12'h41E, 16'h8000, 1'b1);  // skips ORed
    apply("R11", 1'b1, 12'h060, 16'hFFFF, 1'b0);
  endtask

  task automatic t_nop;  // R12
    apply("R12", 1'b1, 12'h000, 16'hA5A5, 1'b1);
  endtask

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_clear();
    t_complement();
    t_rotate();
    t_increment();
    t_sign_skip();
    t_zero_skip();
    t_halt();
    t_multi();
    t_nop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule